// File: doc/BRIEF.md
# Capability Rights and Lifetime Checker

This block checks and transforms one 32-bit capability for one of four capability operations: copy, null (delete), restrict and amplify. The caller supplies the capability, the lifetime level and type of the object it names, the level of the segment that will receive it, a rights mask, and for amplify a type-control word plus the type-definition capability images of the object and of the control word. The block returns the resulting capability, a flag telling the caller to mark the object's descriptor as copied, and a fault code.

Lifetime levels keep a capability from being stored somewhere that outlives its object: a lower level number lives longer, with level 0 the global heap. Amplification adds rights only when the control word's type matches the object's type. All checking is combinational. The outputs are registered one clock after a valid input. Descriptor fetch and result write-back belong to the surrounding logic.

Top module: `cap_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `cap_out`, `copied_set` and `fault` are all zero.
- R2: `out_valid` is high in the cycle after `in_valid` was high, and low otherwise. Results appear on that same cycle.
- R3: Copy (`op`=0) with capability bit 5 clear faults with code 3 when `dst_level` < `obj_level`. Equal or higher destination levels pass.
- R4: When capability bit 5 (unchecked copy) is set, copy never takes the level fault, whatever the two levels are.
- R5: A copy that does not fault returns the capability unchanged with `copied_set`=1. Every other outcome has `copied_set`=0.
- R6: Null (`op`=1) with the delete right (bit 4) set returns an all-zero capability. With bit 4 clear it faults with code 2.
- R7: Restrict (`op`=2) clears each rights bit [4:0] (read 0, write 1, type rights 3:2, delete 4) where `mask` is 1. It never faults.
- R8: Amplify (`op`=3) with control bit 0 set (system type) matches when control bits [13:6] equal `obj_type`. On a match it ORs control bits [5:1] into capability bits [4:0].
- R9: Amplify with control bit 0 clear (dynamic type) matches only when `obj_type` equals the dynamic type code (parameter, default 1) and `obj_tdo` equals `ctl_tdo`.
- R10: An amplify with no type match faults with code 1. Any faulting operation returns the input capability unchanged.
- R11: For copy, restrict and amplify, capability bits [31:5] (unchecked-copy bit, reserved bits and both 12-bit index fields) pass through unchanged.
- R12: A cycle without `in_valid` leaves `cap_out`, `copied_set` and `fault` holding their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 2 | 0 copy, 1 null, 2 restrict, 3 amplify |
| cap_in | input | 32 | Source capability |
| obj_level | input | LVL_W | Lifetime level of the named object |
| obj_type | input | TYPE_W | Type field of the object's descriptor |
| obj_tdo | input | 32 | Type-definition capability image of the object |
| dst_level | input | LVL_W | Lifetime level of the destination segment |
| ctl_word | input | 14 | Type-control word: [0] system flag, [5:1] rights, [13:6] type |
| ctl_tdo | input | 32 | Type-definition capability image held by the control object |
| mask | input | 5 | Rights to clear on restrict |
| out_valid | output | 1 | Result valid |
| cap_out | output | 32 | Resulting capability |
| copied_set | output | 1 | Set the copied flag in the object's descriptor |
| fault | output | 2 | 0 none, 1 type mismatch, 2 no delete right, 3 level violation |

## Verification
The assertions assume that `in_valid`, `op` and the operand buses carry known values from reset onward. They also assume that the operands of a request are only meaningful in the cycle `in_valid` is high. The bench drives every input from time zero and changes inputs only on falling edges. The random mix steers half of the amplify requests onto matching types and equal type-definition images, so the match and mismatch paths are both exercised. It also draws levels from a narrow range so that equal, lower and higher destination levels all occur often.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CAP_W    = 32;
  localparam int RIGHTS_W = 5;
  localparam int DEL_BIT  = 4;
  localparam int UNCHK_BIT = 5;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_NULL = 2'd1,
    OP_RESTRICT = 2'd2,
    OP_AMPLIFY = 2'd3
  } cap_op_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TYPE  = 2'd1,
    FLT_NODEL = 2'd2,
    FLT_LEVEL = 2'd3
  } cap_fault_e;
endpackage

// File: rtl/cap_lifetime_chk.sv
module cap_lifetime_chk #(
  parameter int LVL_W = 8
) (
  input  logic             unchecked,
  input  logic [LVL_W-1:0] obj_level,
  input  logic [LVL_W-1:0] dst_level,
  output logic             level_ok
);
  // A lower level number outlives a higher one; global-heap objects skip the test.
  always_comb begin
    level_ok = unchecked || (dst_level >= obj_level);
  end
endmodule

// File: rtl/cap_type_match.sv
module cap_type_match #(
  parameter int TYPE_W   = 8,
  parameter int CAP_W    = 32,
  parameter logic [TYPE_W-1:0] DYN_TYPE = 1
) (
  input  logic              ctl_system,
  input  logic [TYPE_W-1:0] ctl_type,
  input  logic [TYPE_W-1:0] obj_type,
  input  logic [CAP_W-1:0]  obj_tdo,
  input  logic [CAP_W-1:0]  ctl_tdo,
  output logic              type_ok
);
  logic sys_hit;
  logic dyn_hit;

  always_comb begin
    sys_hit = (ctl_type == obj_type);
    dyn_hit = (obj_type == DYN_TYPE) && (obj_tdo == ctl_tdo);
    type_ok = ctl_system ? sys_hit : dyn_hit;
  end
endmodule

// File: rtl/cap_rights_unit.sv
module cap_rights_unit
  import cap_pkg::*;
#(
  parameter int CW = 32,
  parameter int RW = 5
) (
  input  cap_op_e        op,
  input  logic [CW-1:0]  cap_in,
  input  logic [RW-1:0]  clear_mask,
  input  logic [RW-1:0]  grant,
  output logic [CW-1:0]  cap_res
);
  logic [RW-1:0] cut_rights;
  logic [RW-1:0] add_rights;

  for (genvar i = 0; i < RW; i++) begin : g_bit
    assign cut_rights[i] = cap_in[i] & ~clear_mask[i];
    assign add_rights[i] = cap_in[i] | grant[i];
  end

  always_comb begin
    unique case (op)
      OP_NULL:     cap_res = '0;
      OP_RESTRICT: cap_res = {cap_in[CW-1:RW], cut_rights};
      OP_AMPLIFY:  cap_res = {cap_in[CW-1:RW], add_rights};
      default:     cap_res = cap_in;
    endcase
  end
endmodule

// File: rtl/cap_guard.sv
module cap_guard
  import cap_pkg::*;
#(
  parameter int LVL_W  = 8,
  parameter int TYPE_W = 8,
  parameter logic [TYPE_W-1:0] DYN_TYPE = 1,
  localparam int CTL_W = 1 + RIGHTS_W + TYPE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         op,
  input  logic [CAP_W-1:0]   cap_in,
  input  logic [LVL_W-1:0]   obj_level,
  input  logic [TYPE_W-1:0]  obj_type,
  input  logic [CAP_W-1:0]   obj_tdo,
  input  logic [LVL_W-1:0]   dst_level,
  input  logic [CTL_W-1:0]   ctl_word,
  input  logic [CAP_W-1:0]   ctl_tdo,
  input  logic [RIGHTS_W-1:0] mask,
  output logic               out_valid,
  output logic [CAP_W-1:0]   cap_out,
  output logic               copied_set,
  output logic [1:0]         fault
);
  localparam int GRANT_LO = 1;
  localparam int TYPE_LO  = 1 + RIGHTS_W;

  cap_op_e     op_e;
  logic        level_ok;
  logic        type_ok;
  logic [CAP_W-1:0] cap_res;
  cap_fault_e  flt_next;
  logic [CAP_W-1:0] cap_next;
  logic        copied_next;

  assign op_e = cap_op_e'(op);

  cap_lifetime_chk #(.LVL_W(LVL_W)) u_life (
    .unchecked (cap_in[UNCHK_BIT]),
    .obj_level (obj_level),
    .dst_level (dst_level),
    .level_ok  (level_ok)
  );

  cap_type_match #(.TYPE_W(TYPE_W), .CAP_W(CAP_W), .DYN_TYPE(DYN_TYPE)) u_type (
    .ctl_system (ctl_word[0]),
    .ctl_type   (ctl_word[TYPE_LO +: TYPE_W]),
    .obj_type   (obj_type),
    .obj_tdo    (obj_tdo),
    .ctl_tdo    (ctl_tdo),
    .type_ok    (type_ok)
  );

  cap_rights_unit #(.CW(CAP_W), .RW(RIGHTS_W)) u_rights (
    .op         (op_e),
    .cap_in     (cap_in),
    .clear_mask (mask),
    .grant      (ctl_word[GRANT_LO +: RIGHTS_W]),
    .cap_res    (cap_res)
  );

  // Fault priority: type mismatch, then missing delete right, then level.
  always_comb begin
    logic f_type, f_del, f_lvl;
    f_type = (op_e == OP_AMPLIFY) && !type_ok;
    f_del  = (op_e == OP_NULL) && !cap_in[DEL_BIT];
    f_lvl  = (op_e == OP_COPY) && !level_ok;
    if (f_type)     flt_next = FLT_TYPE;
    else if (f_del) flt_next = FLT_NODEL;
    else if (f_lvl) flt_next = FLT_LEVEL;
    else            flt_next = FLT_NONE;
    cap_next    = (flt_next == FLT_NONE) ? cap_res : cap_in;
    copied_next = (op_e == OP_COPY) && (flt_next == FLT_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      cap_out    <= '0;
      copied_set <= 1'b0;
      fault      <= FLT_NONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cap_out    <= cap_next;
        copied_set <= copied_next;
        fault      <= flt_next;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_copied_clean_r5: assert property (@(posedge clk) disable iff (rst)
    copied_set |-> (fault == FLT_NONE));
  p_unchk_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_COPY && cap_in[UNCHK_BIT]) |=> (fault == FLT_NONE));
  p_null_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_NULL && cap_in[DEL_BIT]) |=> (cap_out == '0));
  p_restrict_cut_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_RESTRICT) |=>
      (fault == FLT_NONE) && ((cap_out[RIGHTS_W-1:0] & $past(mask)) == '0));
  p_amp_superset_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_AMPLIFY) |=> (fault != FLT_NONE) ||
      ((cap_out[RIGHTS_W-1:0] & $past(cap_in[RIGHTS_W-1:0])) == $past(cap_in[RIGHTS_W-1:0])));
  p_index_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != OP_NULL) |=> (cap_out[CAP_W-1:RIGHTS_W] == $past(cap_in[CAP_W-1:RIGHTS_W])));
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cap_out) && $stable(fault) && $stable(copied_set));
endmodule

// File: tb/cap_guard_bench.sv
module cap_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] cap_in = '0;
  logic [7:0]  obj_level = '0;
  logic [7:0]  obj_type = '0;
  logic [31:0] obj_tdo = '0;
  logic [7:0]  dst_level = '0;
  logic [13:0] ctl_word = '0;
  logic [31:0] ctl_tdo = '0;
  logic [4:0]  mask = '0;
  logic        out_valid;
  logic [31:0] cap_out;
  logic        copied_set;
  logic [1:0]  fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cap_guard u_cap_guard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .cap_in(cap_in),
    .obj_level(obj_level), .obj_type(obj_type), .obj_tdo(obj_tdo),
    .dst_level(dst_level), .ctl_word(ctl_word), .ctl_tdo(ctl_tdo), .mask(mask),
    .out_valid(out_valid), .cap_out(cap_out), .copied_set(copied_set), .fault(fault)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: returns {fault, copied, cap}
  function automatic logic [34:0] model(input logic [1:0] o, input logic [31:0] c,
      input logic [7:0] ol, input logic [7:0] ot, input logic [31:0] otd,
      input logic [7:0] dl, input logic [13:0] cw, input logic [31:0] ctd, input logic [4:0] m);
    logic [1:0] f = 2'd0;
    logic [31:0] r = c;
    logic cp = 1'b0;
    logic match;
    case (o)
      2'd0: begin
        if (!c[5] && dl < ol) f = 2'd3;
        else cp = 1'b1;
      end
      2'd1: begin
        if (!c[4]) f = 2'd2;
        else r = 32'd0;
      end
      2'd2: r = {c[31:5], c[4:0] & ~m};
      default: begin
        match = cw[0] ? (cw[13:6] == ot) : (ot == 8'd1 && otd == ctd);
        if (!match) f = 2'd1;
        else r = {c[31:5], c[4:0] | cw[5:1]};
      end
    endcase
    return {f, cp, r};
  endfunction

  task automatic run(input string req, input logic [1:0] o, input logic [31:0] c,
      input logic [7:0] ol, input logic [7:0] ot, input logic [31:0] otd,
      input logic [7:0] dl, input logic [13:0] cw, input logic [31:0] ctd, input logic [4:0] m);
    logic [34:0] e;
    e = model(o, c, ol, ot, otd, dl, cw, ctd, m);
    in_valid = 1'b1; op = o; cap_in = c; obj_level = ol; obj_type = ot; obj_tdo = otd;
    dst_level = dl; ctl_word = cw; ctl_tdo = ctd; mask = m;
    @(negedge clk);
    chk(out_valid == 1'b1, {req, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    chk(cap_out == e[31:0], {req, " cap"}, cap_out, e[31:0]);
    chk(copied_set == e[32], {req, " R5 copied"}, {31'd0, copied_set}, {31'd0, e[32]});
    chk(fault == e[34:33], {req, " fault"}, {30'd0, fault}, {30'd0, e[34:33]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_cap;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && cap_out == 0 && fault == 0 && copied_set == 0, "R1 reset", cap_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && cap_out == 0 && fault == 0 && copied_set == 0, "R1 after reset", cap_out, 32'd0);

    // R3 level check on copy
    run("R3 lower dst",  2'd0, 32'hABC12317, 8'd5, 8'd0, 0, 8'd4, 0, 0, 0);
    run("R3 equal dst",  2'd0, 32'hABC12317, 8'd5, 8'd0, 0, 8'd5, 0, 0, 0);
    run("R3 higher dst", 2'd0, 32'h00100001, 8'd2, 8'd0, 0, 8'd9, 0, 0, 0);
    // R4 unchecked copy skips level
    run("R4 unchecked",  2'd0, 32'h12345620, 8'd200, 8'd0, 0, 8'd0, 0, 0, 0);
    // R6 null
    run("R6 null ok",    2'd1, 32'hFFFFFF1F, 8'd0, 8'd0, 0, 8'd0, 0, 0, 0);
    run("R6 null fault", 2'd1, 32'hFFFFFFEF, 8'd0, 8'd0, 0, 8'd0, 0, 0, 0);
    // R7 restrict
    run("R7 restrict",   2'd2, 32'h5555553F, 8'd0, 8'd0, 0, 8'd0, 0, 0, 5'b10101);
    // R8 amplify system match / R10 mismatch
    run("R8 sys match",  2'd3, 32'h77700001, 8'd0, 8'h2A, 0, 8'd0, {8'h2A, 5'b11110, 1'b1}, 0, 0);
    run("R10 sys miss",  2'd3, 32'h77700001, 8'd0, 8'h2B, 0, 8'd0, {8'h2A, 5'b11110, 1'b1}, 0, 0);
    // R9 dynamic
    run("R9 dyn match",  2'd3, 32'h0F0F0F02, 8'd0, 8'd1, 32'hDEAD0001, 8'd0, {8'h00, 5'b10001, 1'b0}, 32'hDEAD0001, 0);
    run("R10 dyn tdo",   2'd3, 32'h0F0F0F02, 8'd0, 8'd1, 32'hDEAD0001, 8'd0, {8'h00, 5'b10001, 1'b0}, 32'hDEAD0002, 0);
    run("R10 dyn type",  2'd3, 32'h0F0F0F02, 8'd0, 8'd7, 32'hDEAD0001, 8'd0, {8'h07, 5'b10001, 1'b0}, 32'hDEAD0001, 0);
    // R11 index fields kept on restrict with full mask
    run("R11 index",     2'd2, 32'hFEDCBA9F, 8'd0, 8'd0, 0, 8'd0, 0, 0, 5'b11111);

    // R12 hold with idle cycle and changed inputs
    hold_cap = cap_out;
    in_valid = 1'b0; op = 2'd1; cap_in = 32'hFFFFFFFF;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle", {31'd0, out_valid}, 32'd0);
    chk(cap_out == hold_cap, "R12 hold", cap_out, hold_cap);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] o; logic [31:0] c; logic [7:0] ol, dl, ot; logic [13:0] cw;
      logic [31:0] otd, ctd;
      o  = 2'($urandom_range(0, 3));
      c  = $urandom;
      ol = 8'($urandom_range(0, 4));
      dl = 8'($urandom_range(0, 4));
      ot = 8'($urandom_range(0, 3));
      otd = $urandom;
      cw = 14'($urandom);
      ctd = $urandom;
      if ($urandom_range(0, 1) == 1) begin
        cw[13:6] = ot;
        ctd = otd;
      end
      run("R3-mix random", o, c, ol, ot, otd, dl, cw, ctd, 5'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        in_valid = 1'b0;
        hold_cap = cap_out;
        @(negedge clk);
        chk(out_valid == 1'b0 && cap_out == hold_cap, "R12 random hold", cap_out, hold_cap);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule